// File: doc/BRIEF.md
# SMT-Partitioned Return Address Stack

This block predicts return targets for two hardware threads that share one core. Each call pushes its return address onto the stack of the thread that issued it. Each return pops the top entry, and that entry is the predicted target. The storage holds 32 entries. The way those entries are split depends on how many threads are running. While both threads are active, each thread owns a private 16-entry circular stack: thread 0 uses entries 0 to 15 and thread 1 uses entries 16 to 31. When one thread goes idle, the other thread treats the whole array as a single 32-entry circular stack.

A change of mode never rewrites the stored targets. Only the stack pointers are remapped. The pointer of the running thread gains its partition bit as the top bit, so pops that pass the bottom of its own half continue into the sibling's half. As a result, targets left by the thread that just went idle can be returned as predictions. An optional scrub prevents this. When it is enabled and the block enters single-thread mode, the scrub writes a programmable safe address into every entry, one entry per cycle. While the scrub runs, predictions are held invalid and the ready signal is low.

Top module: `ras_smt_part`

## Requirements
- R1: After reset, both prediction valid flags are 0, `single_mode_o` is 0 and `push_rdy_o` is 1.
- R2: In dual mode, each thread's prediction is the most recent target it pushed and has not yet popped, in last-in first-out order. Pushes and pops by one thread do not change the other thread's prediction.
- R3: In dual mode, each thread's stack holds 16 entries and wraps around. After 17 pushes, 16 pops return the newest 16 targets, newest first. After that the prediction is invalid.
- R4: A pop on an empty stack leaves the prediction invalid and does not move the pointer. A later push followed by one pop returns the stack to empty.
- R5: When a thread asserts push and pop in the same cycle, the top entry is replaced by the pushed target and the stack depth does not change.
- R6: One cycle after `thr_active_i` has exactly one bit set, `single_mode_o` is 1 and `solo_thread_o` names the active thread. While the block is in single mode, the idle thread's prediction is invalid and its pushes and pops are ignored.
- R7: In single mode the active thread's pointer covers all 32 entries. With scrub disabled, popping past entry 0 moves to entry 31, so the sibling's stored targets become valid predictions.
- R8: Dual mode returns only when both bits of `thr_active_i` are 1. When both bits are 0, the block stays in single mode. The stored contents survive both mode changes.
- R9: If `scrub_en_i` is 1 when the block moves from dual to single mode, `push_rdy_o` is 0 for exactly 32 cycles. During those cycles both predictions are invalid. Afterwards all 32 entries hold `safe_tgt_i` and are valid.
- R10: Pushes and pops issued while a scrub is running have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_active_i | input | 2 | Per-thread active status (bit t = thread t is active) |
| call_push_i | input | 2 | Per-thread call push request |
| ret_pop_i | input | 2 | Per-thread return pop request |
| push_tgt0_i | input | AW | Return target pushed by thread 0 |
| push_tgt1_i | input | AW | Return target pushed by thread 1 |
| scrub_en_i | input | 1 | Enables a scrub when the block enters single mode |
| safe_tgt_i | input | AW | Safe address that the scrub writes |
| pred_tgt0_o | output | AW | Predicted return target for thread 0 |
| pred_vld0_o | output | 1 | Thread 0 prediction is valid |
| pred_tgt1_o | output | AW | Predicted return target for thread 1 |
| pred_vld1_o | output | 1 | Thread 1 prediction is valid |
| push_rdy_o | output | 1 | Low while a scrub is running |
| single_mode_o | output | 1 | 1 in single-thread mode |
| solo_thread_o | output | 1 | The thread that owns the storage in single mode |

## Verification
Every push or pop is registered, so its effect on a prediction is visible one clock edge after the request is sampled. A change on `thr_active_i` takes one edge to reach the mode outputs and the pointer rules. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and checks the result on the next falling edge. The scrub is counted edge by edge: ready must still be low after the 32nd edge that follows the mode switch, and high after the 33rd. Both checks are made at those points.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_SOLO = 1'b1
    } ras_mode_e;
endpackage

// File: rtl/ras_mode_ctl.sv
module ras_mode_ctl #(
    parameter int unsigned ENTRIES = 32,
    localparam int unsigned CW = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          active_i,
    input  logic                scrub_en_i,
    output ras_pkg::ras_mode_e  mode_o,
    output logic                owner_o,
    output logic                scrub_o,
    output logic [CW-1:0]       scrub_idx_o
);
    import ras_pkg::*;

    typedef struct packed {
        ras_mode_e     mode;
        logic          owner;
        logic          scrub;
        logic [CW-1:0] idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.scrub) begin
            if (ctl_q.idx == CW'(ENTRIES - 1)) ctl_d.scrub = 1'b0;
            else                               ctl_d.idx   = ctl_q.idx + CW'(1);
        end
        unique case (active_i)
            2'b11: ctl_d.mode = MODE_DUAL;
            2'b01: begin ctl_d.mode = MODE_SOLO; ctl_d.owner = 1'b0; end
            2'b10: begin ctl_d.mode = MODE_SOLO; ctl_d.owner = 1'b1; end
            default: ctl_d.mode = MODE_SOLO;
        endcase
        if (ctl_q.mode == MODE_DUAL && ctl_d.mode == MODE_SOLO && scrub_en_i && !ctl_q.scrub) begin
            ctl_d.scrub = 1'b1;
            ctl_d.idx   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: MODE_DUAL, owner: 1'b0, scrub: 1'b0, idx: '0};
        else        ctl_q <= ctl_d;
    end

    assign mode_o      = ctl_q.mode;
    assign owner_o     = ctl_q.owner;
    assign scrub_o     = ctl_q.scrub;
    assign scrub_idx_o = ctl_q.idx;
endmodule

// File: rtl/ras_thread_ptr.sv
module ras_thread_ptr #(
    parameter int unsigned TDEPTH = 16,
    parameter bit          TID    = 1'b0,
    localparam int unsigned PW = $clog2(TDEPTH),
    localparam int unsigned IW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_i,
    input  logic          en_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          top_vld_i,
    output logic [IW-1:0] rd_idx_o,
    output logic          we_o,
    output logic [IW-1:0] wa_o,
    output logic          clr_o
);
    logic [IW-1:0] sp_d, sp_q;
    logic [IW-1:0] rd, up, dn;

    always_comb begin
        rd = dual_i ? {TID, sp_q[PW-1:0]} : sp_q;
        up = dual_i ? {TID, rd[PW-1:0] + PW'(1)} : rd + IW'(1);
        dn = dual_i ? {TID, rd[PW-1:0] - PW'(1)} : rd - IW'(1);
        sp_d  = rd;
        we_o  = 1'b0;
        wa_o  = rd;
        clr_o = 1'b0;
        if (en_i) begin
            if (push_i && pop_i) begin
                we_o = 1'b1;
            end else if (push_i) begin
                we_o = 1'b1;
                wa_o = up;
                sp_d = up;
            end else if (pop_i && top_vld_i) begin
                clr_o = 1'b1;
                sp_d  = dn;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= {TID, {PW{1'b1}}};
        else        sp_q <= sp_d;
    end

    assign rd_idx_o = rd;
endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned AW      = 32,
    localparam int unsigned IW = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           we_i,
    input  logic [1:0][IW-1:0]   wa_i,
    input  logic [1:0][AW-1:0]   wd_i,
    input  logic [1:0]           clr_i,
    input  logic [1:0][IW-1:0]   ra_i,
    input  logic                 scrub_i,
    input  logic [IW-1:0]        scrub_idx_i,
    input  logic [AW-1:0]        safe_i,
    output logic [1:0][AW-1:0]   rd_tgt_o,
    output logic [1:0]           rd_vld_o
);
    typedef struct packed {
        logic [ENTRIES-1:0]         vld;
        logic [ENTRIES-1:0][AW-1:0] tgt;
    } mem_t;

    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int t = 0; t < 2; t++) begin
            if (clr_i[t]) mem_d.vld[ra_i[t]] = 1'b0;
        end
        for (int t = 0; t < 2; t++) begin
            if (we_i[t]) begin
                mem_d.vld[wa_i[t]] = 1'b1;
                mem_d.tgt[wa_i[t]] = wd_i[t];
            end
        end
        if (scrub_i) begin
            mem_d.vld[scrub_idx_i] = 1'b1;
            mem_d.tgt[scrub_idx_i] = safe_i;
        end
        for (int t = 0; t < 2; t++) begin
            rd_tgt_o[t] = mem_q.tgt[ra_i[t]];
            rd_vld_o[t] = mem_q.vld[ra_i[t]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end
endmodule

// File: rtl/ras_smt_part.sv
module ras_smt_part #(
    parameter int unsigned AW     = 32,
    parameter int unsigned TDEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    thr_active_i,
    input  logic [1:0]    call_push_i,
    input  logic [1:0]    ret_pop_i,
    input  logic [AW-1:0] push_tgt0_i,
    input  logic [AW-1:0] push_tgt1_i,
    input  logic          scrub_en_i,
    input  logic [AW-1:0] safe_tgt_i,
    output logic [AW-1:0] pred_tgt0_o,
    output logic          pred_vld0_o,
    output logic [AW-1:0] pred_tgt1_o,
    output logic          pred_vld1_o,
    output logic          push_rdy_o,
    output logic          single_mode_o,
    output logic          solo_thread_o
);
    import ras_pkg::*;

    localparam int unsigned ENTRIES = 2 * TDEPTH;
    localparam int unsigned IW      = $clog2(ENTRIES);

    ras_mode_e           mode;
    logic                owner, scrub, dual;
    logic [IW-1:0]       scrub_idx;
    logic [1:0]          en, we, clr, rd_vld;
    logic [1:0][IW-1:0]  wa, ra;
    logic [1:0][AW-1:0]  wd, rd_tgt;

    assign wd[0] = push_tgt0_i;
    assign wd[1] = push_tgt1_i;
    assign dual  = (mode == MODE_DUAL);

    ras_mode_ctl #(.ENTRIES(ENTRIES)) u_mode (
        .clk(clk), .rst_n(rst_n), .active_i(thr_active_i), .scrub_en_i(scrub_en_i),
        .mode_o(mode), .owner_o(owner), .scrub_o(scrub), .scrub_idx_o(scrub_idx)
    );

    for (genvar t = 0; t < 2; t++) begin : g_thr
        assign en[t] = !scrub && (dual || owner == 1'(t));
        ras_thread_ptr #(.TDEPTH(TDEPTH), .TID(1'(t))) u_ptr (
            .clk(clk), .rst_n(rst_n), .dual_i(dual), .en_i(en[t]),
            .push_i(call_push_i[t]), .pop_i(ret_pop_i[t]), .top_vld_i(rd_vld[t]),
            .rd_idx_o(ra[t]), .we_o(we[t]), .wa_o(wa[t]), .clr_o(clr[t])
        );
    end

    ras_store #(.ENTRIES(ENTRIES), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(we), .wa_i(wa), .wd_i(wd), .clr_i(clr),
        .ra_i(ra), .scrub_i(scrub), .scrub_idx_i(scrub_idx), .safe_i(safe_tgt_i),
        .rd_tgt_o(rd_tgt), .rd_vld_o(rd_vld)
    );

    assign pred_tgt0_o   = rd_tgt[0];
    assign pred_tgt1_o   = rd_tgt[1];
    assign pred_vld0_o   = rd_vld[0] && en[0];
    assign pred_vld1_o   = rd_vld[1] && en[1];
    assign push_rdy_o    = !scrub;
    assign single_mode_o = !dual;
    assign solo_thread_o = owner;
endmodule

// File: rtl/ras_smt_chk.sv
module ras_smt_chk #(
    parameter int unsigned AW        = 32,
    parameter int unsigned SCRUB_LEN = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    thr_active_i,
    input logic [1:0]    call_push_i,
    input logic [1:0]    ret_pop_i,
    input logic [AW-1:0] push_tgt0_i,
    input logic [AW-1:0] pred_tgt0_o,
    input logic          pred_vld0_o,
    input logic          pred_vld1_o,
    input logic          push_rdy_o,
    input logic          single_mode_o,
    input logic          solo_thread_o
);
    logic [7:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           lo_cnt <= '0;
        else if (!push_rdy_o) lo_cnt <= lo_cnt + 8'd1;
        else                  lo_cnt <= '0;
    end

    // R6
    idle_t1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode_o && !solo_thread_o) |-> !pred_vld1_o);

    // R6
    idle_t0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode_o && solo_thread_o) |-> !pred_vld0_o);

    // R6
    enter_solo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_active_i != 2'b11) |=> single_mode_o);

    // R8
    enter_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_active_i == 2'b11) |=> !single_mode_o);

    // R9
    scrub_hides_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !push_rdy_o |-> (!pred_vld0_o && !pred_vld1_o));

    // R9
    scrub_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !push_rdy_o |-> (lo_cnt < 8'(SCRUB_LEN)));

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_mode_o && push_rdy_o && call_push_i[0] && !ret_pop_i[0])
        |=> (single_mode_o || (pred_vld0_o && pred_tgt0_o == $past(push_tgt0_i))));
endmodule

bind ras_smt_part ras_smt_chk #(.AW(AW), .SCRUB_LEN(2 * TDEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .thr_active_i(thr_active_i), .call_push_i(call_push_i),
    .ret_pop_i(ret_pop_i), .push_tgt0_i(push_tgt0_i), .pred_tgt0_o(pred_tgt0_o),
    .pred_vld0_o(pred_vld0_o), .pred_vld1_o(pred_vld1_o), .push_rdy_o(push_rdy_o),
    .single_mode_o(single_mode_o), .solo_thread_o(solo_thread_o)
);

// File: tb/ras_smt_part_test.sv
`timescale 1ns/1ps
module ras_smt_part_test;
    localparam int AW = 32;
    localparam logic [AW-1:0] SAFE = 32'h5AFE_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    thr_active_i = 2'b11;
    logic [1:0]    call_push_i = '0;
    logic [1:0]    ret_pop_i = '0;
    logic [AW-1:0] push_tgt0_i = '0;
    logic [AW-1:0] push_tgt1_i = '0;
    logic          scrub_en_i = 1'b0;
    logic [AW-1:0] safe_tgt_i = '0;
    logic [AW-1:0] pred_tgt0_o, pred_tgt1_o;
    logic          pred_vld0_o, pred_vld1_o, push_rdy_o, single_mode_o, solo_thread_o;

    int checks = 0;
    int errors = 0;

    ras_smt_part #(.AW(AW), .TDEPTH(16)) uut (.*);

    always #10 clk = ~clk;

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(int t, logic [AW-1:0] v);
        call_push_i[t] = 1'b1;
        if (t == 0) push_tgt0_i = v; else push_tgt1_i = v;
        step();
        call_push_i = '0;
    endtask

    task automatic pop(int t);
        ret_pop_i[t] = 1'b1;
        step();
        ret_pop_i = '0;
    endtask

    task automatic t_reset();
        check("R1 vld0", 32'(pred_vld0_o), 32'd0);
        check("R1 vld1", 32'(pred_vld1_o), 32'd0);
        check("R1 mode", 32'(single_mode_o), 32'd0);
        check("R1 rdy", 32'(push_rdy_o), 32'd1);
    endtask

    task automatic t_lifo();
        push(0, 32'hA);
        push(0, 32'hB);
        push(1, 32'hC);
        check("R2 t0 top", pred_tgt0_o, 32'hB);
        check("R2 t1 top", pred_tgt1_o, 32'hC);
        pop(0);
        check("R2 t0 after pop", pred_tgt0_o, 32'hA);
        check("R2 t1 untouched", pred_tgt1_o, 32'hC);
        pop(0);
        check("R2 t0 drained", 32'(pred_vld0_o), 32'd0);
        pop(0);
        check("R4 empty pop vld", 32'(pred_vld0_o), 32'd0);
        push(0, 32'hD);
        check("R4 push after empty", pred_tgt0_o, 32'hD);
        pop(0);
        check("R4 back to empty", 32'(pred_vld0_o), 32'd0);
    endtask

    task automatic t_overflow();
        pop(1);
        for (int i = 1; i <= 17; i++) push(1, 32'h100 + 32'(i));
        for (int i = 17; i >= 2; i--) begin
            check("R3 wrap order vld", 32'(pred_vld1_o), 32'd1);
            check("R3 wrap order tgt", pred_tgt1_o, 32'h100 + 32'(i));
            pop(1);
        end
        check("R3 oldest lost", 32'(pred_vld1_o), 32'd0);
        check("R2 t0 isolated", 32'(pred_vld0_o), 32'd0);
    endtask

    task automatic t_replace();
        push(0, 32'hE1);
        push(0, 32'hE2);
        call_push_i[0] = 1'b1; ret_pop_i[0] = 1'b1; push_tgt0_i = 32'hE3;
        step();
        call_push_i = '0; ret_pop_i = '0;
        check("R5 replaced top", pred_tgt0_o, 32'hE3);
        pop(0);
        check("R5 depth kept", pred_tgt0_o, 32'hE1);
        pop(0);
        check("R5 drained", 32'(pred_vld0_o), 32'd0);
    endtask

    task automatic t_leak();
        for (int i = 1; i <= 16; i++) push(1, 32'h200 + 32'(i));
        push(0, 32'hF0);
        thr_active_i = 2'b01;
        step();
        check("R6 single mode", 32'(single_mode_o), 32'd1);
        check("R6 owner", 32'(solo_thread_o), 32'd0);
        check("R6 idle pred invalid", 32'(pred_vld1_o), 32'd0);
        check("R6 owner top kept", pred_tgt0_o, 32'hF0);
        push(1, 32'hBAD);
        pop(0);
        check("R7 leak vld", 32'(pred_vld0_o), 32'd1);
        check("R7 sibling target", pred_tgt0_o, 32'h20F);
        pop(0);
        check("R7 sibling next", pred_tgt0_o, 32'h20E);
        thr_active_i = 2'b00;
        step();
        check("R8 stays single", 32'(single_mode_o), 32'd1);
        thr_active_i = 2'b11;
        step();
        check("R8 dual again", 32'(single_mode_o), 32'd0);
        check("R8 t1 contents kept", pred_tgt1_o, 32'h210);
        check("R6 ignored push vld", 32'(pred_vld1_o), 32'd1);
    endtask

    task automatic t_scrub();
        scrub_en_i = 1'b1;
        safe_tgt_i = SAFE;
        thr_active_i = 2'b10;
        step();
        check("R6 owner t1", 32'(solo_thread_o), 32'd1);
        check("R9 rdy low", 32'(push_rdy_o), 32'd0);
        check("R9 pred hidden", 32'(pred_vld1_o), 32'd0);
        push(1, 32'hBEEF);
        for (int k = 3; k <= 32; k++) step();
        check("R9 rdy low at 32", 32'(push_rdy_o), 32'd0);
        step();
        check("R9 rdy back", 32'(push_rdy_o), 32'd1);
        check("R9 pred valid", 32'(pred_vld1_o), 32'd1);
        check("R10 push ignored", pred_tgt1_o, SAFE);
        for (int i = 0; i < 31; i++) begin
            pop(1);
            check("R9 safe entry", pred_tgt1_o, SAFE);
            check("R9 safe vld", 32'(pred_vld1_o), 32'd1);
        end
        pop(1);
        check("R9 all 32 drained", 32'(pred_vld1_o), 32'd0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lifo();
        t_overflow();
        t_replace();
        t_leak();
        t_scrub();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule